// File: doc/BRIEF.md
# USB 2.0 PHY Power Sequencer

This block brings a PHY with up to two ports out of reset and back down again. A request to bring a port up runs a fixed chain of steps: the reference clock turns on, the shared power-on reset lifts, one write through the PHY's test-register port turns on the PHY's internal clock, and then the UTMI reset of the requesting port lifts. Each step is followed by a minimum settle time before the next one starts. When the chain is complete, the port's ready flag comes up and a one-cycle completion pulse fires.

A request to take a port down reverses the chain. The port's UTMI reset is asserted first, then the shared power-on reset, then the reference clock is gated. The shared steps are skipped while another port is still ready, so that port keeps working.

All settle times are derived from the clock-frequency parameter and rounded up to whole cycles. Requests that arrive while a chain is running are latched and served afterwards. None is lost.

Top module: `uphy_pwr_seq`

## Requirements
- R1: Out of reset: `ref_clk_en`=0, `por_rst`=1, every `utmi_rst` bit=1, `port_ready`=0, `wr_req`=0, `seq_done`=0.
- R2: An accepted bring-up request raises `ref_clk_en` on the clock edge that samples it. `por_rst` falls exactly C_REF cycles later, where C_REF = ceil(CLK_FREQ_HZ x 100 us).
- R3: `wr_req` rises exactly C_POR = ceil(CLK_FREQ_HZ x 300 us) cycles after `por_rst` falls. While it is high, `wr_port`=0, `wr_addr`=0x06 and `wr_data`=0x04 (bit 2 set). It stays high until an edge samples `wr_done`=1, and falls on that edge.
- R4: The requesting port's `utmi_rst` bit falls exactly C_PHY = ceil(CLK_FREQ_HZ x 2 ms) cycles after the edge that sampled `wr_done`.
- R5: C_FIN = ceil(CLK_FREQ_HZ x 2 us) cycles after that, the port's `port_ready` bit rises and `seq_done` is high for one cycle. A ready port always has its UTMI reset released.
- R6: A take-down request with no other port ready has this timing, counted from the accepting edge:
  - On the accepting edge, the port's `utmi_rst` bit is set and its `port_ready` bit is cleared.
  - One edge later, `por_rst` rises.
  - One edge after that, `ref_clk_en` falls and `seq_done` pulses.
- R7: A take-down request while another port is ready sets only that port's `utmi_rst` bit and clears its ready bit. `seq_done` pulses on the accepting edge. `por_rst` and `ref_clk_en` are unchanged.
- R8: Requests that arrive while a chain is running are latched and served once it ends, with none dropped. Take-down requests are served before bring-up requests, and the lower port index wins within each kind.
- R9: A bring-up of one port while another port is ready leaves the other port's `utmi_rst` and `port_ready` bits unchanged.
- R10: `por_rst` is never low while `ref_clk_en` is low. No `utmi_rst` bit is low while `por_rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | NPORT | One-cycle bring-up request per port |
| exit_req | input | NPORT | One-cycle take-down request per port |
| wr_done | input | 1 | Test-register port has completed the write |
| ref_clk_en | output | 1 | Reference clock enable |
| por_rst | output | 1 | Shared power-on reset, 1 = asserted |
| utmi_rst | output | NPORT | Per-port UTMI reset, 1 = asserted |
| wr_req | output | 1 | Test-register write request |
| wr_port | output | TP_PORT_W | Test-register target port |
| wr_addr | output | TP_ADDR_W | Test-register address |
| wr_data | output | TP_DATA_W | Test-register write data |
| port_ready | output | NPORT | Port fully brought up |
| seq_done | output | 1 | One-cycle pulse when a chain ends |

## Verification
Every output transition is due a fixed number of cycles after the one before it. The gaps are C_REF, C_POR, C_PHY and C_FIN for the settle steps, a single cycle for each take-down step, and the bridge's three-cycle reply time for the write. The scoreboard is loaded with the expected transitions in order, each paired with its cycle gap. A monitor samples the outputs at every falling edge, counts cycles since the previous transition, and compares each change it sees against the next queued item. Changes on the same edge are listed in a fixed signal order with a gap of zero. A wrong order, a gap that is off by one cycle, or any change that is not expected is therefore reported at the cycle where it happens.

// File: rtl/uphy_seq_pkg.sv
`timescale 1ns/1ps
package uphy_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_SETTLE,
        ST_POR_SETTLE,
        ST_CFG_WRITE,
        ST_PHY_SETTLE,
        ST_UTMI_SETTLE,
        ST_DOWN_POR,
        ST_DOWN_CLK
    } seq_state_e;

    // Minimum settle times in nanoseconds
    localparam longint unsigned T_REF_NS = 64'd100_000;
    localparam longint unsigned T_POR_NS = 64'd300_000;
    localparam longint unsigned T_PHY_NS = 64'd2_000_000;
    localparam longint unsigned T_FIN_NS = 64'd2_000;

    // Round up so that a wait is never shorter than its minimum
    function automatic longint unsigned ns_to_cycles(longint unsigned f_hz,
                                                     longint unsigned ns);
        return (f_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/uphy_settle_timer.sv
`timescale 1ns/1ps
module uphy_settle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (cnt_q != '1)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == limit);
endmodule

// File: rtl/uphy_req_arb.sv
`timescale 1ns/1ps
module uphy_req_arb #(
    parameter int NPORT = 2,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] init_req,
    input  logic [NPORT-1:0] exit_req,
    input  logic             take,
    output logic             sel_valid,
    output logic             sel_exit,
    output logic [PW-1:0]    sel_port
);
    typedef struct packed {
        logic [NPORT-1:0] init;
        logic [NPORT-1:0] exit;
    } pend_t;

    pend_t pend_d, pend_q;
    logic [NPORT-1:0] init_all, exit_all, sel_1h;

    always_comb begin
        init_all  = pend_q.init | init_req;
        exit_all  = pend_q.exit | exit_req;
        sel_valid = 1'b0;
        sel_exit  = 1'b0;
        sel_port  = '0;
        // Later assignments win: take-down over bring-up, low index over high
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (init_all[p]) begin
                sel_valid = 1'b1;
                sel_exit  = 1'b0;
                sel_port  = PW'(p);
            end
        end
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (exit_all[p]) begin
                sel_valid = 1'b1;
                sel_exit  = 1'b1;
                sel_port  = PW'(p);
            end
        end
        sel_1h      = NPORT'(1) << sel_port;
        pend_d.init = init_all & ~((take && !sel_exit) ? sel_1h : '0);
        pend_d.exit = exit_all & ~((take &&  sel_exit) ? sel_1h : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end
endmodule

// File: rtl/uphy_pwr_seq.sv
`timescale 1ns/1ps
module uphy_pwr_seq
    import uphy_seq_pkg::*;
#(
    parameter int              NPORT       = 2,
    parameter longint unsigned CLK_FREQ_HZ = 64'd250_000_000,
    parameter int              TP_PORT_W   = 3,
    parameter int              TP_ADDR_W   = 8,
    parameter int              TP_DATA_W   = 8,
    parameter int              CFG_PORT    = 0,
    parameter int              CFG_ADDR    = 6,
    parameter int              CFG_DATA    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORT-1:0]     init_req,
    input  logic [NPORT-1:0]     exit_req,
    input  logic                 wr_done,
    output logic                 ref_clk_en,
    output logic                 por_rst,
    output logic [NPORT-1:0]     utmi_rst,
    output logic                 wr_req,
    output logic [TP_PORT_W-1:0] wr_port,
    output logic [TP_ADDR_W-1:0] wr_addr,
    output logic [TP_DATA_W-1:0] wr_data,
    output logic [NPORT-1:0]     port_ready,
    output logic                 seq_done
);
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam longint unsigned CYC_REF = ns_to_cycles(CLK_FREQ_HZ, T_REF_NS);
    localparam longint unsigned CYC_POR = ns_to_cycles(CLK_FREQ_HZ, T_POR_NS);
    localparam longint unsigned CYC_PHY = ns_to_cycles(CLK_FREQ_HZ, T_PHY_NS);
    localparam longint unsigned CYC_FIN = ns_to_cycles(CLK_FREQ_HZ, T_FIN_NS);
    localparam int CW = $clog2(CYC_PHY + 1);

    typedef struct packed {
        seq_state_e             state;
        logic [PW-1:0]          port;
        logic                   ref_en;
        logic                   por;
        logic [NPORT-1:0]       utmi;
        logic [NPORT-1:0]       ready;
        logic                   wr_req;
        logic [TP_PORT_W-1:0]   wr_port;
        logic [TP_ADDR_W-1:0]   wr_addr;
        logic [TP_DATA_W-1:0]   wr_data;
        logic                   done;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             take, restart, hit;
    logic [CW-1:0]    limit;
    logic             sel_valid, sel_exit;
    logic [PW-1:0]    sel_port;
    logic [NPORT-1:0] sel_1h;

    uphy_req_arb #(.NPORT(NPORT)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_req  (init_req),
        .exit_req  (exit_req),
        .take      (take),
        .sel_valid (sel_valid),
        .sel_exit  (sel_exit),
        .sel_port  (sel_port)
    );

    uphy_settle_timer #(.CW(CW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .hit     (hit)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        take    = 1'b0;
        restart = 1'b0;
        limit   = '0;
        sel_1h  = NPORT'(1) << sel_port;
        case (r_q.state)
            ST_IDLE: begin
                restart = 1'b1;
                if (sel_valid) begin
                    take     = 1'b1;
                    r_d.port = sel_port;
                    if (sel_exit) begin
                        r_d.utmi[sel_port]  = 1'b1;
                        r_d.ready[sel_port] = 1'b0;
                        // Shared clock and reset stay up while another port runs
                        if (|(r_q.ready & ~sel_1h))
                            r_d.done = 1'b1;
                        else
                            r_d.state = ST_DOWN_POR;
                    end else begin
                        r_d.ref_en = 1'b1;
                        r_d.state  = ST_CLK_SETTLE;
                    end
                end
            end
            ST_CLK_SETTLE: begin
                limit = CW'(CYC_REF - 1);
                if (hit) begin
                    r_d.por   = 1'b0;
                    restart   = 1'b1;
                    r_d.state = ST_POR_SETTLE;
                end
            end
            ST_POR_SETTLE: begin
                limit = CW'(CYC_POR - 1);
                if (hit) begin
                    r_d.wr_req  = 1'b1;
                    r_d.wr_port = TP_PORT_W'(CFG_PORT);
                    r_d.wr_addr = TP_ADDR_W'(CFG_ADDR);
                    r_d.wr_data = TP_DATA_W'(CFG_DATA);
                    r_d.state   = ST_CFG_WRITE;
                end
            end
            ST_CFG_WRITE: begin
                restart = 1'b1;
                if (wr_done) begin
                    r_d.wr_req  = 1'b0;
                    r_d.wr_port = '0;
                    r_d.wr_addr = '0;
                    r_d.wr_data = '0;
                    r_d.state   = ST_PHY_SETTLE;
                end
            end
            ST_PHY_SETTLE: begin
                limit = CW'(CYC_PHY - 1);
                if (hit) begin
                    r_d.utmi[r_q.port] = 1'b0;
                    restart            = 1'b1;
                    r_d.state          = ST_UTMI_SETTLE;
                end
            end
            ST_UTMI_SETTLE: begin
                limit = CW'(CYC_FIN - 1);
                if (hit) begin
                    r_d.ready[r_q.port] = 1'b1;
                    r_d.done            = 1'b1;
                    r_d.state           = ST_IDLE;
                end
            end
            ST_DOWN_POR: begin
                r_d.por   = 1'b1;
                r_d.state = ST_DOWN_CLK;
            end
            ST_DOWN_CLK: begin
                r_d.ref_en = 1'b0;
                r_d.done   = 1'b1;
                r_d.state  = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.por   <= 1'b1;
            r_q.utmi  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_clk_en = r_q.ref_en;
    assign por_rst    = r_q.por;
    assign utmi_rst   = r_q.utmi;
    assign wr_req     = r_q.wr_req;
    assign wr_port    = r_q.wr_port;
    assign wr_addr    = r_q.wr_addr;
    assign wr_data    = r_q.wr_data;
    assign port_ready = r_q.ready;
    assign seq_done   = r_q.done;
endmodule

// File: rtl/uphy_pwr_seq_chk.sv
`timescale 1ns/1ps
module uphy_pwr_seq_chk
    import uphy_seq_pkg::*;
#(
    parameter int              NPORT       = 2,
    parameter longint unsigned CLK_FREQ_HZ = 64'd250_000_000,
    parameter int              TP_PORT_W   = 3,
    parameter int              TP_ADDR_W   = 8,
    parameter int              TP_DATA_W   = 8,
    parameter int              CFG_PORT    = 0,
    parameter int              CFG_ADDR    = 6,
    parameter int              CFG_DATA    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_done,
    input logic                 ref_clk_en,
    input logic                 por_rst,
    input logic [NPORT-1:0]     utmi_rst,
    input logic                 wr_req,
    input logic [TP_PORT_W-1:0] wr_port,
    input logic [TP_ADDR_W-1:0] wr_addr,
    input logic [TP_DATA_W-1:0] wr_data,
    input logic [NPORT-1:0]     port_ready
);
    localparam longint unsigned CYC_REF = ns_to_cycles(CLK_FREQ_HZ, T_REF_NS);
    localparam longint unsigned CYC_PHY = ns_to_cycles(CLK_FREQ_HZ, T_PHY_NS);
    localparam int CW = $clog2(CYC_PHY + 1);

    logic [CW-1:0] clk_on_cnt, since_wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_on_cnt   <= '0;
            since_wr_cnt <= '0;
        end else begin
            if (!ref_clk_en)
                clk_on_cnt <= '0;
            else if (clk_on_cnt != '1)
                clk_on_cnt <= clk_on_cnt + 1'b1;
            if (wr_req && wr_done)
                since_wr_cnt <= '0;
            else if (since_wr_cnt != '1)
                since_wr_cnt <= since_wr_cnt + 1'b1;
        end
    end

    // R10
    clk_before_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_clk_en |-> por_rst);

    // R10
    por_before_utmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~utmi_rst != '0) |-> !por_rst);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> wr_req);

    // R3
    wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_port == TP_PORT_W'(CFG_PORT) && wr_addr == TP_ADDR_W'(CFG_ADDR)
                    && wr_data == TP_DATA_W'(CFG_DATA)));

    // R2
    ref_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_rst) |-> (clk_on_cnt >= CW'(CYC_REF)));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // R5
        ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_ready[p] |-> !utmi_rst[p]);

        // R4
        phy_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(utmi_rst[p]) |-> (since_wr_cnt >= CW'(CYC_PHY)));

        // R6
        down_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(utmi_rst[p]) |-> !port_ready[p]);
    end
endmodule

bind uphy_pwr_seq uphy_pwr_seq_chk #(
    .NPORT       (NPORT),
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .TP_PORT_W   (TP_PORT_W),
    .TP_ADDR_W   (TP_ADDR_W),
    .TP_DATA_W   (TP_DATA_W),
    .CFG_PORT    (CFG_PORT),
    .CFG_ADDR    (CFG_ADDR),
    .CFG_DATA    (CFG_DATA)
) i_uphy_pwr_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_done    (wr_done),
    .ref_clk_en (ref_clk_en),
    .por_rst    (por_rst),
    .utmi_rst   (utmi_rst),
    .wr_req     (wr_req),
    .wr_port    (wr_port),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .port_ready (port_ready)
);

// File: tb/test_uphy_pwr_seq.sv
`timescale 1ns/1ps
module test_uphy_pwr_seq;
    // 10 MHz settle base: 100 us, 300 us, 2 ms, 2 us in cycles
    localparam longint unsigned FREQ = 64'd10_000_000;
    localparam int C_REF = 1000;
    localparam int C_POR = 3000;
    localparam int C_PHY = 20000;
    localparam int C_FIN = 20;
    localparam int BR_LAT = 3;
    // signal ids: 0 ref_clk_en 1 por_rst 2 wr_req 3 utmi0 4 utmi1 5 ready0 6 ready1 7 seq_done

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] init_req, exit_req;
    logic       wr_done;
    logic       ref_clk_en, por_rst, wr_req, seq_done;
    logic [1:0] utmi_rst, port_ready;
    logic [2:0] wr_port;
    logic [7:0] wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    int q_id[$];
    int q_val[$];
    int q_dly[$];
    string q_req[$];

    always #2 clk = ~clk;

    uphy_pwr_seq #(.CLK_FREQ_HZ(FREQ)) i_uphy_pwr_seq (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
        .wr_done(wr_done), .ref_clk_en(ref_clk_en), .por_rst(por_rst),
        .utmi_rst(utmi_rst), .wr_req(wr_req), .wr_port(wr_port),
        .wr_addr(wr_addr), .wr_data(wr_data), .port_ready(port_ready),
        .seq_done(seq_done)
    );

    function automatic logic [7:0] out_vec();
        return {seq_done, port_ready[1], port_ready[0], utmi_rst[1], utmi_rst[0],
                wr_req, por_rst, ref_clk_en};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int id, int val, int dly, string req);
        q_id.push_back(id);
        q_val.push_back(val);
        q_dly.push_back(dly);
        q_req.push_back(req);
    endtask

    // Monitor: compare every output change against the scoreboard queue
    logic [7:0] mon_prev;
    int mon_cyc = 0;
    int mon_last = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_prev = out_vec();
        end else begin
            logic [7:0] cur;
            cur = out_vec();
            mon_cyc++;
            for (int id = 0; id < 8; id++) begin
                if (cur[id] != mon_prev[id]) begin
                    int delta;
                    delta = mon_cyc - mon_last;
                    mon_last = mon_cyc;
                    if (q_id.size() == 0) begin
                        check(1'b0, "R9", "unexpected change on signal", id, -1);
                    end else begin
                        int e_id, e_val, e_dly;
                        string e_req;
                        e_id = q_id.pop_front();
                        e_val = q_val.pop_front();
                        e_dly = q_dly.pop_front();
                        e_req = q_req.pop_front();
                        check(e_id == id, e_req, "signal id", id, e_id);
                        check(e_val == int'(cur[id]), e_req, "new value", int'(cur[id]), e_val);
                        if (e_dly >= 0)
                            check(e_dly == delta, e_req, "cycle gap", delta, e_dly);
                    end
                    if (id == 2 && cur[id]) begin
                        check(wr_port == 3'd0, "R3", "wr_port", wr_port, 0);
                        check(wr_addr == 8'h06, "R3", "wr_addr", wr_addr, 6);
                        check(wr_data == 8'h04, "R3", "wr_data", wr_data, 4);
                    end
                end
            end
            mon_prev = cur;
        end
    end

    // Test-register bridge model: replies BR_LAT cycles after the request
    initial begin
        wr_done = 1'b0;
        forever begin
            @(negedge clk);
            if (wr_req) begin
                repeat (BR_LAT - 1) @(negedge clk);
                wr_done = 1'b1;
                @(negedge clk);
                wr_done = 1'b0;
            end
        end
    end

    task automatic pulse_init(int p);
        init_req[p] = 1'b1;
        @(negedge clk);
        init_req[p] = 1'b0;
    endtask

    task automatic pulse_exit(int p);
        exit_req[p] = 1'b1;
        @(negedge clk);
        exit_req[p] = 1'b0;
    endtask

    task automatic drain(string req);
        while (q_id.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        check(q_id.size() == 0, req, "events still pending", q_id.size(), 0);
    endtask

    task automatic push_full_up(int p, string first_dly_req);
        push(0, 1, -1, first_dly_req);
        push(1, 0, C_REF, "R2");
        push(2, 1, C_POR, "R3");
        push(2, 0, BR_LAT, "R3");
        push(3 + p, 0, C_PHY, "R4");
        push(5 + p, 1, C_FIN, "R5");
        push(7, 1, 0, "R5");
        push(7, 0, 1, "R5");
    endtask

    task automatic push_full_down(int p);
        push(3 + p, 1, -1, "R6");
        push(5 + p, 0, 0, "R6");
        push(1, 1, 1, "R6");
        push(0, 0, 1, "R6");
        push(7, 1, 0, "R6");
        push(7, 0, 1, "R6");
    endtask

    initial begin
        rst_n = 1'b0;
        init_req = '0;
        exit_req = '0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(ref_clk_en == 1'b0, "R1", "ref_clk_en", ref_clk_en, 0);
        check(por_rst == 1'b1, "R1", "por_rst", por_rst, 1);
        check(utmi_rst == 2'b11, "R1", "utmi_rst", utmi_rst, 3);
        check(port_ready == 2'b00, "R1", "port_ready", port_ready, 0);
        check(wr_req == 1'b0, "R1", "wr_req", wr_req, 0);
        check(seq_done == 1'b0, "R1", "seq_done", seq_done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Bring up port 0; queue a port-1 bring-up and a port-0 take-down meanwhile (R8)
        push(0, 1, -1, "R2");
        push(1, 0, C_REF, "R2");
        push(2, 1, C_POR, "R3");
        push(2, 0, BR_LAT, "R3");
        push(3, 0, C_PHY, "R4");
        push(5, 1, C_FIN, "R5");
        push(7, 1, 0, "R5");
        push(3, 1, 1, "R8");
        push(5, 0, 0, "R6");
        push(7, 0, 0, "R5");
        push(1, 1, 1, "R6");
        push(0, 0, 1, "R6");
        push(7, 1, 0, "R6");
        push(0, 1, 1, "R8");
        push(7, 0, 0, "R6");
        push(1, 0, C_REF, "R2");
        push(2, 1, C_POR, "R3");
        push(2, 0, BR_LAT, "R3");
        push(4, 0, C_PHY, "R4");
        push(6, 1, C_FIN, "R5");
        push(7, 1, 0, "R5");
        push(7, 0, 1, "R5");
        pulse_init(0);
        repeat (100) @(negedge clk);
        pulse_init(1);
        pulse_exit(0);
        drain("R8");
        check(port_ready == 2'b10, "R8", "port_ready after queue", port_ready, 2);

        // Bring up port 0 while port 1 is ready (R9)
        push(2, 1, -1, "R9");
        push(2, 0, BR_LAT, "R3");
        push(3, 0, C_PHY, "R4");
        push(5, 1, C_FIN, "R9");
        push(7, 1, 0, "R5");
        push(7, 0, 1, "R5");
        pulse_init(0);
        drain("R9");
        check(utmi_rst == 2'b00, "R9", "utmi_rst both released", utmi_rst, 0);
        check(port_ready == 2'b11, "R9", "both ports ready", port_ready, 3);

        // Take down port 1 while port 0 stays ready (R7)
        push(4, 1, -1, "R7");
        push(6, 0, 0, "R7");
        push(7, 1, 0, "R7");
        push(7, 0, 1, "R7");
        pulse_exit(1);
        drain("R7");
        check(por_rst == 1'b0, "R7", "por_rst kept released", por_rst, 0);
        check(ref_clk_en == 1'b1, "R7", "ref_clk_en kept on", ref_clk_en, 1);
        check(port_ready == 2'b01, "R7", "port_ready", port_ready, 1);

        // Full take-down of port 0 (R6)
        push_full_down(0);
        pulse_exit(0);
        drain("R6");
        check(utmi_rst == 2'b11 && por_rst && !ref_clk_en, "R6", "all down",
              int'({ref_clk_en, por_rst, utmi_rst}), 7);

        // Fresh bring-up of port 1 from cold (R2)
        push_full_up(1, "R2");
        pulse_init(1);
        drain("R2");
        check(port_ready == 2'b10, "R5", "port 1 ready", port_ready, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired R8 actual=%0d expected=%0d", q_id.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule